// File: doc/BRIEF.md
# Nine-bit serial command/data receiver

This block is the write-only serial front end of a display controller. A host drives three lines into it: an active-low enable, a serial clock and a serial data line. Each transfer is a nine-bit packet. Its first bit is a flag that says what kind of byte follows, and the next eight bits are that byte, most significant bit first. Packets may follow each other with no gap for as long as the enable stays low.

The receiver runs on a fast system clock. It passes the three serial lines through synchronizers and finds serial-clock rising edges in the system clock domain. Each finished packet produces a one-cycle pulse on exactly one of two outputs. Command bytes go to a command strobe for the controller's decoder. Data bytes go to a RAM write port, which carries a pixel-memory address that counts up after every data byte. The controller's command logic can load that address directly. An asynchronous reset abandons any half-received packet and re-arms the receiver, even in the middle of an enable-low window.

Top module: `ser3w_rx`

## Requirements
- R1: While `sce_n` is high, serial clock pulses are ignored: no output pulses and `ram_addr` does not change.
- R2: A packet whose first sampled bit is 0 ends with `cmd_valid` pulsing and `cmd_byte` holding the eight bits that followed the flag.
- R3: A packet whose first sampled bit is 1 ends with `ram_we` pulsing, `ram_wdata` holding the byte and `ram_addr` holding the address in force before the write.
- R4: The eight payload bits are sampled on rising `sclk` edges, most significant bit first; a payload of 0x80 and one of 0x01 are delivered unswapped.
- R5: After each data byte `ram_addr` advances by one and wraps from its all-ones value to zero; command bytes leave it unchanged.
- R6: While `sce_n` stays low, the rising `sclk` edge after the last payload bit is taken as the flag of the next packet, with no gap required.
- R7: If `sce_n` rises before a packet's ninth bit, the partial bits are discarded, nothing is emitted, and the next packet after a new falling edge starts from its flag.
- R8: Asserting `rst_n` low clears `ram_addr` to zero and both strobes to zero and abandons any partial packet; if `sce_n` is low when `rst_n` is released, the next rising `sclk` edge is a flag bit.
- R9: Each completed packet causes exactly one of `cmd_valid` and `ram_we` to be high, for one system clock cycle; the two are never high together.
- R10: A high `addr_load` sets `ram_addr` to `addr_load_val` on the next clock edge; when it is high in the same cycle as a `ram_we` pulse, that write uses the old address, and the loaded value replaces the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| sce_n | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdin | input | 1 | Serial data line |
| addr_load | input | 1 | Loads the RAM address from `addr_load_val` |
| addr_load_val | input | ADDR_W | Value for an address load |
| cmd_valid | output | 1 | One-cycle strobe for a received command byte |
| cmd_byte | output | 8 | Received command byte |
| ram_we | output | 1 | One-cycle RAM write strobe for a received data byte |
| ram_wdata | output | 8 | Received data byte |
| ram_addr | output | ADDR_W | Current RAM write address |

## Verification
An address load from the command side and the auto-increment after a data write can fall in the same system clock cycle. The bench provokes this by timing `addr_load` to the cycle in which `ram_we` is high on the last bit of a data packet. It judges the result in two ways. The logged write must carry the pre-load address, and the address seen afterwards must be the loaded value, not that value plus one. Load-beats-increment is also checked cycle by cycle by a property on the address counter.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    localparam int DATA_W   = 8;
    localparam int PKT_BITS = DATA_W + 1;
    localparam int CNT_W    = $clog2(PKT_BITS);
    localparam int SH_W     = DATA_W - 1;

    // Register set of the packet assembler
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;     // bits taken so far in this packet
        logic              flag;    // 1 = data byte, 0 = command byte
        logic [SH_W-1:0]   sh;      // payload bits received before the last
        logic [DATA_W-1:0] octet;   // completed byte
        logic              cmd_v;   // command strobe
        logic              ram_v;   // data strobe
    } shift_state_t;

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/ser3w_edge.sv
module ser3w_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sce_n_s,
    output logic sclk_rise,
    output logic link_on
);

    logic sclk_p_d, sclk_p_q;

    always_comb begin
        sclk_p_d = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_p_q <= 1'b0;
        else        sclk_p_q <= sclk_p_d;
    end

    assign sclk_rise = sclk_s & ~sclk_p_q;
    assign link_on   = ~sce_n_s;

    // Two rising edges cannot be seen on consecutive cycles
    assert_rise_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);

endmodule

// File: rtl/ser3w_shift.sv
module ser3w_shift
    import ser3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_on,
    input  logic              sclk_rise,
    input  logic              sdin_s,
    output logic              cmd_v,
    output logic              ram_v,
    output logic [DATA_W-1:0] octet
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_BITS - 1);

    shift_state_t st_d, st_q;
    logic         pkt_end;

    always_comb begin
        st_d       = st_q;
        st_d.cmd_v = 1'b0;
        st_d.ram_v = 1'b0;
        pkt_end    = 1'b0;
        if (!link_on) begin
            // enable inactive: bit counter and assembler held in initial state
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
            st_d.sh   = '0;
        end else if (sclk_rise) begin
            if (st_q.cnt == '0) begin
                st_d.flag = sdin_s;
            end else begin
                st_d.sh = {st_q.sh[SH_W-2:0], sdin_s};
            end
            if (st_q.cnt == LAST) begin
                pkt_end    = 1'b1;
                st_d.cnt   = '0;
                st_d.octet = {st_q.sh, sdin_s};
                st_d.cmd_v = ~st_q.flag;
                st_d.ram_v = st_q.flag;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_v = st_q.cmd_v;
    assign ram_v = st_q.ram_v;
    assign octet = st_q.octet;

    // Enable inactive: assembler idle and silent on the next cycle
    assert_ce_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_on |=> (st_q.cnt == '0) && !st_q.cmd_v && !st_q.ram_v);

    // After the ninth bit the counter is ready for the next flag
    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> (st_q.cnt == '0) && (st_q.cmd_v || st_q.ram_v));

    // A strobe only follows a completed packet
    assert_strobe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.cmd_v || st_d.ram_v) |-> (link_on && sclk_rise && st_q.cnt == LAST));

endmodule

// File: rtl/ser3w_addr.sv
module ser3w_addr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)      addr_d = load_val;
        else if (step) addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr_q == $past(addr_q) + 1'b1);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr_q));

    assert_addr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_q == $past(load_val));

endmodule

// File: rtl/ser3w_rx.sv
module ser3w_rx
    import ser3w_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sce_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_load_val,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [ADDR_W-1:0] ram_addr
);

    localparam int          LINES    = 3;
    localparam logic [LINES-1:0] LINE_RST = 3'b100; // enable idles high

    logic [LINES-1:0]  lines_s;
    logic              sce_n_s, sclk_s, sdin_s;
    logic              sclk_rise, link_on;
    logic              cmd_v, ram_v;
    logic [DATA_W-1:0] octet;

    ser3w_sync #(
        .W       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sce_n, sclk, sdin}),
        .dout  (lines_s)
    );

    assign {sce_n_s, sclk_s, sdin_s} = lines_s;

    ser3w_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sce_n_s   (sce_n_s),
        .sclk_rise (sclk_rise),
        .link_on   (link_on)
    );

    ser3w_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_on   (link_on),
        .sclk_rise (sclk_rise),
        .sdin_s    (sdin_s),
        .cmd_v     (cmd_v),
        .ram_v     (ram_v),
        .octet     (octet)
    );

    ser3w_addr #(
        .AW (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ram_v),
        .load     (addr_load),
        .load_val (addr_load_val),
        .addr     (ram_addr)
    );

    assign cmd_valid = cmd_v;
    assign cmd_byte  = octet;
    assign ram_we    = ram_v;
    assign ram_wdata = octet;

    assert_one_sink_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, ram_we}));

    assert_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_we_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    assert_cmd_keeps_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !addr_load) |=> $stable(ram_addr));

endmodule

// File: tb/ser3w_rx_tb.sv
module ser3w_rx_tb;

    localparam int AW = 7;
    localparam int NV = 10;
    // {flag, byte}: flag 1 = data, 0 = command
    localparam logic [8:0] VEC [NV] = '{
        9'h0E1, 9'h180, 9'h101, 9'h000, 9'h1FF,
        9'h0FF, 9'h155, 9'h1AA, 9'h012, 9'h134
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sce_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_load_val = '0;
    logic          cmd_valid, ram_we;
    logic [7:0]    cmd_byte, ram_wdata;
    logic [AW-1:0] ram_addr;

    int errors = 0, checks = 0;
    int n_cmd = 0, n_ram = 0;
    logic [7:0]    cmd_log  [64];
    logic [7:0]    dat_log  [64];
    logic [AW-1:0] adr_log  [64];
    bit done = 0;

    always #2 clk = ~clk;

    ser3w_rx #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sce_n(sce_n), .sclk(sclk), .sdin(sdin),
        .addr_load(addr_load), .addr_load_val(addr_load_val),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_addr(ram_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Event monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && ram_we) check(0, "R9 both strobes", 1, 0);
            if (cmd_valid && n_cmd < 64) begin cmd_log[n_cmd] = cmd_byte; n_cmd++; end
            if (ram_we && n_ram < 64) begin
                dat_log[n_ram] = ram_wdata; adr_log[n_ram] = ram_addr; n_ram++;
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; coll pulses addr_load in the cycle a write strobe would show
    task automatic send_bit(input logic b, input bit coll);
        sdin = b; sclk = 1'b0;
        wait_n(4);
        sclk = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            addr_load = coll && (k == 3);
        end
        addr_load = 1'b0;
    endtask

    task automatic send_pkt(input logic [8:0] p, input bit coll);
        for (int i = 8; i >= 0; i--) send_bit(p[i], coll && (i == 0));
        sclk = 1'b0;
    endtask

    task automatic ce_low();  sce_n = 1'b0; wait_n(4); endtask
    task automatic ce_high(); sclk = 1'b0; wait_n(2); sce_n = 1'b1; wait_n(6); endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, r0, ec, er;
        logic [AW-1:0] ea;
        wait_n(3);
        // R8: reset state
        check(!cmd_valid && !ram_we, "R8 strobes in reset", {cmd_valid, ram_we}, 0);
        check(ram_addr == 0, "R8 addr in reset", ram_addr, 0);
        rst_n = 1'b1;
        wait_n(4);

        // R2 R3 R4 R5 R6: table walked back-to-back in one enable window
        ce_low();
        for (int v = 0; v < NV; v++) send_pkt(VEC[v], 0);
        wait_n(6);
        ce_high();
        ec = 0; er = 0; ea = '0;
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][8]) begin
                check(dat_log[er] == VEC[v][7:0], "R3 R4 data byte", dat_log[er], VEC[v][7:0]);
                check(adr_log[er] == ea, "R5 data address", adr_log[er], ea);
                ea = ea + 1'b1; er++;
            end else begin
                check(cmd_log[ec] == VEC[v][7:0], "R2 R4 command byte", cmd_log[ec], VEC[v][7:0]);
                ec++;
            end
        end
        check(n_cmd == ec, "R6 command count", n_cmd, ec);
        check(n_ram == er, "R6 data count", n_ram, er);
        check(ram_addr == ea, "R5 address after stream", ram_addr, ea);

        // R1: clocks while enable high are ignored
        c0 = n_cmd; r0 = n_ram;
        for (int i = 0; i < 20; i++) send_bit(i[0], 0);
        sclk = 1'b0; wait_n(6);
        check(n_cmd == c0 && n_ram == r0, "R1 no strobe", n_cmd + n_ram, c0 + r0);
        check(ram_addr == ea, "R1 addr held", ram_addr, ea);

        // R7: partial packet discarded, fresh start afterwards
        ce_low();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 0);
        ce_high();
        check(n_cmd == c0 && n_ram == r0, "R7 partial discarded", n_cmd + n_ram, c0 + r0);
        ce_low();
        send_pkt(9'h0A5, 0);
        wait_n(6);
        ce_high();
        check(n_cmd == c0 + 1 && cmd_log[c0] == 8'hA5, "R7 fresh packet", cmd_log[c0], 8'hA5);
        check(n_ram == r0 && ram_addr == ea, "R5 command keeps addr", ram_addr, ea);

        // R5: wrap from all-ones to zero
        addr_load_val = '1; addr_load = 1'b1; wait_n(1); addr_load = 1'b0; wait_n(1);
        check(ram_addr == {AW{1'b1}}, "R10 load", ram_addr, {AW{1'b1}});
        r0 = n_ram;
        ce_low(); send_pkt(9'h1C3, 0); wait_n(6); ce_high();
        check(adr_log[r0] == {AW{1'b1}}, "R5 write at max", adr_log[r0], {AW{1'b1}});
        check(ram_addr == 0, "R5 wrap to zero", ram_addr, 0);

        // R10: load in the same cycle as a write strobe
        addr_load_val = 7'h05; addr_load = 1'b1; wait_n(1); addr_load = 1'b0;
        addr_load_val = 7'h20;
        r0 = n_ram;
        ce_low(); send_pkt(9'h177, 1); wait_n(6); ce_high();
        check(n_ram == r0 + 1 && dat_log[r0] == 8'h77, "R10 collide data", dat_log[r0], 8'h77);
        check(adr_log[r0] == 7'h05, "R10 write uses old addr", adr_log[r0], 7'h05);
        check(ram_addr == 7'h20, "R10 load wins", ram_addr, 7'h20);

        // R8: reset mid-packet with enable held low
        c0 = n_cmd; r0 = n_ram;
        ce_low();
        for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
        sclk = 1'b0; wait_n(2);
        rst_n = 1'b0; wait_n(2);
        check(!cmd_valid && !ram_we && ram_addr == 0, "R8 cleared", ram_addr, 0);
        rst_n = 1'b1; wait_n(4);
        send_pkt(9'h13C, 0); wait_n(6); ce_high();
        check(n_ram == r0 + 1 && n_cmd == c0, "R8 one packet after reset", n_ram - r0, 1);
        check(dat_log[r0] == 8'h3C && adr_log[r0] == 0, "R8 flag rearmed", dat_log[r0], 8'h3C);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule